// File: doc/BRIEF.md
# Parallel-Port Adapter Register Access Sequencer

This block sits on the host side of a parallel-port link to a disk adapter. It turns a single register access request into the series of data-line and control-line updates that the adapter expects, and it samples the status, data or control lines to rebuild a read byte. A request names a register bank, a 7-bit register index, the direction, the write byte and a transfer mode from 0 to 5. The block finishes each request with a one-cycle done pulse and the read byte.

Modes 0 to 2 drive the raw port lines. A read in mode 0 takes the byte as two 4-bit halves from the status lines. A read in mode 1 takes five bits from the status lines and three from the control readback. A read in mode 2 releases the data lines and reads them directly. All three modes write a full byte on the data lines. Modes 3 to 5 use an abstract enhanced-port interface: an address strobe, then a data strobe. The address placed on the lines is XOR-scrambled with a key that depends on the mode and the direction.

A programmable gap of idle cycles follows every sequence step, so slow adapters can be paced without any change to the sequencing logic.

Top module: `ppa_reg_seq`

## Requirements
- R1: The line address is {bank, index}: bit 7 is set for the control bank and clear for the file bank, before scrambling.
- R2: A mode-0 read puts address^0x39 on the data lines. It then drives control 0x01 and then 0x03, samples status, drives 0x01, samples status again, and ends with control 0x04.
- R3: A mode-0 read returns {second status sample[7:4], first status sample[7:4]}.
- R4: A mode-1 read puts address^0x31 on the data lines. It then steps control 0x01, data address^0x31 AND 0x37, control 0x03, control 0x05, data address^0x31 OR 0xF0. It samples status and the 3-bit control readback together, ends with control 0x04, and returns {ctrl_readback[2:0], status[7:3]}.
- R5: A mode-2 read puts address^0x29 on the data lines and then steps control 0x01, 0x21, 0x23. It samples the data lines while the data drivers are off (pp_data_oe is the inverse of control bit 5), ends with control 0x04, and returns the sampled byte.
- R6: A write in modes 0 to 2 puts address^0x19 on the data lines, drives control 0x01, puts the write byte on the data lines, then drives control 0x03 and then 0x04.
- R7: A write in modes 3 to 5 issues an address strobe carrying address^0x40, then a data strobe with epp_we high carrying the write byte, then drives control 0x04.
- R8: A read in modes 3 to 5 issues an address strobe carrying the unscrambled address, drives control 0x24, issues a data strobe with epp_we low, drives control 0x04, and returns epp_rdata as sampled while that strobe is high. The two strobes are never high together.
- R9: With cfg_gap = G > 0, successive line updates inside a request are at least G+1 cycles apart, and no port line moves during the gap.
- R10: busy rises the cycle after a request is accepted and stays high until done. done is a one-cycle pulse with busy low. Requests raised while busy are ignored.
- R11: A mode value of 6 or 7 moves no port line and ends with done, err high and rd_data = 0xFF.
- R12: After reset, control lines are 0x04, data lines are 0x00 and driven, and busy, done and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_gap | input | GAP_W | Idle cycles inserted after each sequence step |
| req_valid | input | 1 | Request; accepted when not busy |
| req_bank | input | 1 | 1 selects the control register bank |
| req_idx | input | 7 | Register index |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 8 | Write byte |
| req_mode | input | 3 | Transfer mode 0..5 |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | High with done for an undefined mode |
| rd_data | output | 8 | Read byte, valid from done |
| pp_data_o | output | 8 | Port data lines out |
| pp_data_oe | output | 1 | Data line drive enable |
| pp_data_i | input | 8 | Port data lines in |
| pp_ctrl_o | output | 8 | Port control lines |
| pp_ctrl_i | input | 3 | Control line readback, low bits |
| pp_status_i | input | 8 | Port status lines |
| epp_addr_stb | output | 1 | Enhanced-port address cycle strobe |
| epp_data_stb | output | 1 | Enhanced-port data cycle strobe |
| epp_we | output | 1 | Data cycle direction, 1 = write |
| epp_wdata | output | 8 | Address or data byte for the strobe |
| epp_rdata | input | 8 | Read data during a read data strobe |

## Verification
The hardest case to reach is byte assembly in modes 0 and 1. The samples are taken at points that have no visible marker on the ports, so the bench makes the status lines a function of the current control value. Each sample point then sees a distinct byte, and a sample taken at the wrong step shows up as a wrong result. The other hard case is a request held high through a busy transfer. The bench keeps req_valid asserted with a different mode and drops it only on the cycle that done appears. It then checks that the line trace still matches the first request alone and that no second done appears.

// File: rtl/ppa_pkg.sv
package ppa_pkg;

    localparam int unsigned STEP_W      = 4;
    localparam logic [2:0]  MODE_EPP_LO = 3'd3;
    localparam logic [2:0]  MODE_MAX    = 3'd5;
    localparam logic [7:0]  CTRL_IDLE   = 8'h04;
    localparam logic [7:0]  BAD_BYTE    = 8'hFF;

    typedef enum logic [3:0] {
        ST_DATA_ADDR,     // data lines <= scrambled address
        ST_DATA_ADDR_LO,  // data lines <= scrambled address & 0x37
        ST_DATA_ADDR_HI,  // data lines <= scrambled address | 0xF0
        ST_DATA_WR,       // data lines <= write byte
        ST_CTRL,          // control lines <= cval
        ST_SMP_A_STAT,    // first sample from status lines
        ST_SMP_B_STAT,    // second sample, status upper half
        ST_SMP_B_CTRL,    // second sample, control readback
        ST_SMP_A_DATA,    // first sample from data lines
        ST_EPP_ADDR,      // address strobe
        ST_EPP_WR,        // data strobe, write
        ST_EPP_RD,        // data strobe, read
        ST_END
    } step_kind_e;

    typedef struct packed {
        step_kind_e  kind;
        logic [7:0]  cval;
    } step_t;

    typedef enum logic [1:0] {S_IDLE, S_RUN, S_GAP, S_FIN} seq_state_e;

    typedef struct packed {
        seq_state_e          state;
        logic [STEP_W-1:0]   step_idx;
        logic [2:0]          mode;
        logic                write;
        logic [7:0]          addr;
        logic [7:0]          wdata;
        logic [7:0]          ctrl;
        logic [7:0]          data;
        logic                epp_a;
        logic                epp_d;
        logic                epp_we;
        logic [7:0]          epp_wdata;
        logic [7:0]          samp_a;
        logic [3:0]          samp_b;
        logic [7:0]          rdata;
        logic                done;
        logic                err;
    } seq_regs_t;

    function automatic logic [7:0] addr_key(input logic [2:0] mode, input logic wr);
        logic [7:0] k;
        if (wr) begin
            k = (mode >= MODE_EPP_LO) ? 8'h40 : 8'h19;
        end else begin
            case (mode)
                3'd0:    k = 8'h39;
                3'd1:    k = 8'h31;
                3'd2:    k = 8'h29;
                default: k = 8'h00;
            endcase
        end
        return k;
    endfunction

endpackage

// File: rtl/ppa_step_rom.sv
module ppa_step_rom
    import ppa_pkg::*;
(
    input  logic [2:0]        mode,
    input  logic              write,
    input  logic [STEP_W-1:0] idx,
    output step_t             step
);

    function automatic step_t mk(input step_kind_e k, input logic [7:0] v);
        step_t s;
        s.kind = k;
        s.cval = v;
        return s;
    endfunction

    always_comb begin
        step = mk(ST_END, 8'h00);
        if (mode >= MODE_EPP_LO) begin
            if (write) begin
                case (idx)
                    4'd0:    step = mk(ST_EPP_ADDR, 8'h00);
                    4'd1:    step = mk(ST_EPP_WR,   8'h00);
                    4'd2:    step = mk(ST_CTRL,     CTRL_IDLE);
                    default: step = mk(ST_END,      8'h00);
                endcase
            end else begin
                case (idx)
                    4'd0:    step = mk(ST_EPP_ADDR, 8'h00);
                    4'd1:    step = mk(ST_CTRL,     8'h24);
                    4'd2:    step = mk(ST_EPP_RD,   8'h00);
                    4'd3:    step = mk(ST_CTRL,     CTRL_IDLE);
                    default: step = mk(ST_END,      8'h00);
                endcase
            end
        end else if (write) begin
            case (idx)
                4'd0:    step = mk(ST_DATA_ADDR, 8'h00);
                4'd1:    step = mk(ST_CTRL,      8'h01);
                4'd2:    step = mk(ST_DATA_WR,   8'h00);
                4'd3:    step = mk(ST_CTRL,      8'h03);
                4'd4:    step = mk(ST_CTRL,      CTRL_IDLE);
                default: step = mk(ST_END,       8'h00);
            endcase
        end else begin
            case (mode)
                3'd0: begin
                    case (idx)
                        4'd0:    step = mk(ST_DATA_ADDR,  8'h00);
                        4'd1:    step = mk(ST_CTRL,       8'h01);
                        4'd2:    step = mk(ST_CTRL,       8'h03);
                        4'd3:    step = mk(ST_DATA_ADDR,  8'h00);
                        4'd4:    step = mk(ST_SMP_A_STAT, 8'h00);
                        4'd5:    step = mk(ST_CTRL,       8'h01);
                        4'd6:    step = mk(ST_SMP_B_STAT, 8'h00);
                        4'd7:    step = mk(ST_CTRL,       CTRL_IDLE);
                        default: step = mk(ST_END,        8'h00);
                    endcase
                end
                3'd1: begin
                    case (idx)
                        4'd0:    step = mk(ST_DATA_ADDR,    8'h00);
                        4'd1:    step = mk(ST_CTRL,         8'h01);
                        4'd2:    step = mk(ST_DATA_ADDR_LO, 8'h00);
                        4'd3:    step = mk(ST_CTRL,         8'h03);
                        4'd4:    step = mk(ST_CTRL,         8'h05);
                        4'd5:    step = mk(ST_DATA_ADDR_HI, 8'h00);
                        4'd6:    step = mk(ST_SMP_A_STAT,   8'h00);
                        4'd7:    step = mk(ST_SMP_B_CTRL,   8'h00);
                        4'd8:    step = mk(ST_CTRL,         CTRL_IDLE);
                        default: step = mk(ST_END,          8'h00);
                    endcase
                end
                default: begin
                    case (idx)
                        4'd0:    step = mk(ST_DATA_ADDR,  8'h00);
                        4'd1:    step = mk(ST_CTRL,       8'h01);
                        4'd2:    step = mk(ST_CTRL,       8'h21);
                        4'd3:    step = mk(ST_CTRL,       8'h23);
                        4'd4:    step = mk(ST_SMP_A_DATA, 8'h00);
                        4'd5:    step = mk(ST_CTRL,       CTRL_IDLE);
                        default: step = mk(ST_END,        8'h00);
                    endcase
                end
            endcase
        end
    end

endmodule

// File: rtl/ppa_byte_merge.sv
module ppa_byte_merge (
    input  logic [2:0] mode,
    input  logic [7:0] samp_a,
    input  logic [3:0] samp_b,
    output logic [7:0] byte_o
);

    always_comb begin
        case (mode)
            3'd0:    byte_o = {samp_b, samp_a[7:4]};
            3'd1:    byte_o = {samp_b[2:0], samp_a[7:3]};
            default: byte_o = samp_a;
        endcase
    end

endmodule

// File: rtl/ppa_gap_timer.sv
module ppa_gap_timer #(
    parameter int unsigned GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [GAP_W-1:0] len,
    output logic             active
);

    logic [GAP_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = len;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign active = (cnt_q != '0);

    // R9
    gap_count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && active) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/ppa_reg_seq.sv
module ppa_reg_seq
    import ppa_pkg::*;
#(
    parameter int unsigned GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GAP_W-1:0] cfg_gap,
    input  logic             req_valid,
    input  logic             req_bank,
    input  logic [6:0]       req_idx,
    input  logic             req_write,
    input  logic [7:0]       req_wdata,
    input  logic [2:0]       req_mode,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [7:0]       rd_data,
    output logic [7:0]       pp_data_o,
    output logic             pp_data_oe,
    input  logic [7:0]       pp_data_i,
    output logic [7:0]       pp_ctrl_o,
    input  logic [2:0]       pp_ctrl_i,
    input  logic [7:0]       pp_status_i,
    output logic             epp_addr_stb,
    output logic             epp_data_stb,
    output logic             epp_we,
    output logic [7:0]       epp_wdata,
    input  logic [7:0]       epp_rdata
);

    seq_regs_t  q, d;
    step_t      cur;
    logic [7:0] merged;
    logic [7:0] scr_addr;
    logic       gap_start;
    logic       gap_active;

    ppa_step_rom u_rom (
        .mode  (q.mode),
        .write (q.write),
        .idx   (q.step_idx),
        .step  (cur)
    );

    ppa_byte_merge u_merge (
        .mode   (q.mode),
        .samp_a (q.samp_a),
        .samp_b (q.samp_b),
        .byte_o (merged)
    );

    ppa_gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (gap_start),
        .len    (cfg_gap),
        .active (gap_active)
    );

    assign scr_addr  = q.addr ^ addr_key(q.mode, q.write);
    assign gap_start = (q.state == S_RUN) && (cur.kind != ST_END) && (cfg_gap != '0);

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        d.err   = 1'b0;
        d.epp_a = 1'b0;
        d.epp_d = 1'b0;
        if (q.epp_d && !q.epp_we) begin
            d.samp_a = epp_rdata;
        end
        case (q.state)
            S_IDLE: begin
                if (req_valid) begin
                    d.mode     = req_mode;
                    d.write    = req_write;
                    d.addr     = {req_bank, req_idx};
                    d.wdata    = req_wdata;
                    d.step_idx = '0;
                    d.state    = (req_mode > MODE_MAX) ? S_FIN : S_RUN;
                end
            end
            S_RUN: begin
                d.step_idx = q.step_idx + 1'b1;
                case (cur.kind)
                    ST_DATA_ADDR:    d.data   = scr_addr;
                    ST_DATA_ADDR_LO: d.data   = scr_addr & 8'h37;
                    ST_DATA_ADDR_HI: d.data   = scr_addr | 8'hF0;
                    ST_DATA_WR:      d.data   = q.wdata;
                    ST_CTRL:         d.ctrl   = cur.cval;
                    ST_SMP_A_STAT:   d.samp_a = pp_status_i;
                    ST_SMP_A_DATA:   d.samp_a = pp_data_i;
                    ST_SMP_B_STAT:   d.samp_b = pp_status_i[7:4];
                    ST_SMP_B_CTRL:   d.samp_b = {1'b0, pp_ctrl_i};
                    ST_EPP_ADDR: begin
                        d.epp_a     = 1'b1;
                        d.epp_wdata = scr_addr;
                    end
                    ST_EPP_WR: begin
                        d.epp_d     = 1'b1;
                        d.epp_we    = 1'b1;
                        d.epp_wdata = q.wdata;
                    end
                    ST_EPP_RD: begin
                        d.epp_d  = 1'b1;
                        d.epp_we = 1'b0;
                    end
                    default: begin
                    end
                endcase
                if (cur.kind == ST_END) begin
                    d.done  = 1'b1;
                    d.rdata = merged;
                    d.state = S_IDLE;
                end else if (cfg_gap != '0) begin
                    d.state = S_GAP;
                end
            end
            S_GAP: begin
                if (!gap_active) d.state = S_RUN;
            end
            S_FIN: begin
                d.done  = 1'b1;
                d.err   = 1'b1;
                d.rdata = BAD_BYTE;
                d.state = S_IDLE;
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.ctrl <= CTRL_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy         = (q.state != S_IDLE);
    assign done         = q.done;
    assign err          = q.err;
    assign rd_data      = q.rdata;
    assign pp_data_o    = q.data;
    assign pp_data_oe   = ~q.ctrl[5];
    assign pp_ctrl_o    = q.ctrl;
    assign epp_addr_stb = q.epp_a;
    assign epp_data_stb = q.epp_d;
    assign epp_we       = q.epp_we;
    assign epp_wdata    = q.epp_wdata;

    // R10
    accept_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

    // R10
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    gap_lines_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_GAP) |=> ($stable(pp_ctrl_o) && $stable(pp_data_o)
                                && !epp_addr_stb && !epp_data_stb));

    // R11
    bad_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_mode > MODE_MAX)
            |=> ($stable(pp_ctrl_o) && $stable(pp_data_o) && !epp_addr_stb && !epp_data_stb));

    // R11
    bad_mode_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_FIN) |=> (done && err && rd_data == BAD_BYTE));

    // R5
    data_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_RUN && cur.kind == ST_SMP_A_DATA) |-> !pp_data_oe);

    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(epp_addr_stb && epp_data_stb));

endmodule

// File: tb/ppa_reg_seq_tb.sv
module ppa_reg_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_gap = 8'd0;
    logic       req_valid = 1'b0, req_bank = 1'b0, req_write = 1'b0;
    logic [6:0] req_idx = '0;
    logic [7:0] req_wdata = '0;
    logic [2:0] req_mode = '0;
    logic       busy, done, err;
    logic [7:0] rd_data, pp_data_o, pp_ctrl_o, pp_status_i, epp_wdata;
    logic       pp_data_oe, epp_addr_stb, epp_data_stb, epp_we;
    logic [7:0] pd_in = 8'h9E, epp_rd = 8'hC3;
    logic [2:0] ct_in = 3'b110;
    logic [7:0] st_a = 8'hA5, st_b = 8'h3C, st_c = 8'hB8;

    always #5 clk = ~clk;

    // status lines answer according to the current control value
    assign pp_status_i = (pp_ctrl_o == 8'h03) ? st_a :
                         (pp_ctrl_o == 8'h01) ? st_b :
                         (pp_ctrl_o == 8'h05) ? st_c : 8'h00;

    ppa_reg_seq #(.GAP_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_gap(cfg_gap),
        .req_valid(req_valid), .req_bank(req_bank), .req_idx(req_idx),
        .req_write(req_write), .req_wdata(req_wdata), .req_mode(req_mode),
        .busy(busy), .done(done), .err(err), .rd_data(rd_data),
        .pp_data_o(pp_data_o), .pp_data_oe(pp_data_oe), .pp_data_i(pd_in),
        .pp_ctrl_o(pp_ctrl_o), .pp_ctrl_i(ct_in), .pp_status_i(pp_status_i),
        .epp_addr_stb(epp_addr_stb), .epp_data_stb(epp_data_stb), .epp_we(epp_we),
        .epp_wdata(epp_wdata), .epp_rdata(epp_rd)
    );

    int n_chk = 0, n_fail = 0;
    int cyc = 0;

    // observed line events: 0 data, 1 ctrl, 2 addr strobe, 3 write strobe, 4 read strobe
    int   ev_n = 0;
    int   ev_t [64];
    int   ev_v [64];
    int   ev_c [64];
    int   ex_n = 0;
    int   ex_t [64];
    int   ex_v [64];
    logic [7:0] prev_data = 8'h00, prev_ctrl = 8'h04;
    logic [7:0] md_data = 8'h00, md_ctrl = 8'h04;
    logic oe_at23 = 1'b1;

    task automatic push(input int t, input int v);
        if (ev_n < 64) begin
            ev_t[ev_n] = t; ev_v[ev_n] = v; ev_c[ev_n] = cyc;
        end
        ev_n++;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (pp_data_o != prev_data) push(0, pp_data_o);
            if (pp_ctrl_o != prev_ctrl) push(1, pp_ctrl_o);
            if (epp_addr_stb) push(2, epp_wdata);
            if (epp_data_stb && epp_we) push(3, epp_wdata);
            if (epp_data_stb && !epp_we) push(4, 0);
            if (pp_ctrl_o == 8'h23) oe_at23 = pp_data_oe;
        end
        prev_data = pp_data_o;
        prev_ctrl = pp_ctrl_o;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic ex(input int t, input int v);
        if (t == 0 && v == md_data) return;
        if (t == 1 && v == md_ctrl) return;
        if (t == 0) md_data = v[7:0];
        if (t == 1) md_ctrl = v[7:0];
        ex_t[ex_n] = t; ex_v[ex_n] = v; ex_n++;
    endtask

    task automatic cmp_events(input string req);
        chk(ev_n == ex_n, req, "event count", ev_n, ex_n);
        for (int i = 0; i < ex_n && i < ev_n; i++) begin
            chk(ev_t[i] == ex_t[i] && ev_v[i] == ex_v[i], req, $sformatf("event %0d", i),
                ev_t[i] * 256 + ev_v[i], ex_t[i] * 256 + ex_v[i]);
        end
    endtask

    task automatic do_req(input logic bank, input logic [6:0] idx, input logic wr,
                          input logic [7:0] wd, input logic [2:0] md, input bit hold,
                          output logic [7:0] rd, output logic er);
        int n;
        bit busy_ok;
        @(negedge clk);
        ev_n = 0; ex_n = 0;
        req_bank = bank; req_idx = idx; req_write = wr; req_wdata = wd; req_mode = md;
        req_valid = 1'b1;
        @(negedge clk);
        if (hold) begin
            req_mode = 3'd0; req_write = 1'b0; req_idx = 7'h55;
        end else begin
            req_valid = 1'b0;
        end
        busy_ok = 1'b1;
        n = 0;
        while (!done && n < 3000) begin
            if (!busy) busy_ok = 1'b0;
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        rd = rd_data;
        er = err;
        chk(done, "R10", "done reached", done, 1);
        chk(busy_ok, "R10", "busy held until done", busy_ok, 1);
        chk(!busy, "R10", "busy low at done", busy, 0);
        @(negedge clk);
        chk(!done, "R10", "done one cycle", done, 0);
    endtask

    task automatic t_reset();
        chk(pp_ctrl_o == 8'h04, "R12", "ctrl", pp_ctrl_o, 8'h04);
        chk(pp_data_o == 8'h00 && pp_data_oe, "R12", "data/oe", {pp_data_oe, pp_data_o}, 9'h100);
        chk(!busy && !done, "R12", "busy/done", {busy, done}, 0);
        chk(!epp_addr_stb && !epp_data_stb, "R12", "strobes", {epp_addr_stb, epp_data_stb}, 0);
    endtask

    task automatic t_nib_read();
        logic [7:0] rd; logic er;
        do_req(1'b0, 7'h07, 1'b0, 8'h00, 3'd0, 1'b0, rd, er);
        ex(0, 8'h07 ^ 8'h39); ex(1, 8'h01); ex(1, 8'h03); ex(0, 8'h07 ^ 8'h39);
        ex(1, 8'h01); ex(1, 8'h04);
        cmp_events("R2");
        chk(rd == 8'h3A, "R3", "nibble byte", rd, 8'h3A);
        chk(!er, "R3", "err low", er, 0);
    endtask

    task automatic t_nib_ctrl_bank();
        logic [7:0] rd; logic er;
        st_a = 8'h5F; st_b = 8'hC0;
        do_req(1'b1, 7'h06, 1'b0, 8'h00, 3'd0, 1'b0, rd, er);
        ex(0, 8'h86 ^ 8'h39); ex(1, 8'h01); ex(1, 8'h03); ex(1, 8'h01); ex(1, 8'h04);
        cmp_events("R1");
        chk(rd == 8'hC5, "R3", "nibble byte 2", rd, 8'hC5);
        st_a = 8'hA5; st_b = 8'h3C;
    endtask

    task automatic t_split_read();
        logic [7:0] rd; logic er;
        do_req(1'b0, 7'h0A, 1'b0, 8'h00, 3'd1, 1'b0, rd, er);
        ex(0, 8'h3B); ex(1, 8'h01); ex(0, 8'h33); ex(1, 8'h03); ex(1, 8'h05);
        ex(0, 8'hFB); ex(1, 8'h04);
        cmp_events("R4");
        chk(rd == 8'hD7, "R4", "5/3 byte", rd, 8'hD7);
    endtask

    task automatic t_byte_read();
        logic [7:0] rd; logic er;
        oe_at23 = 1'b1;
        do_req(1'b0, 7'h05, 1'b0, 8'h00, 3'd2, 1'b0, rd, er);
        ex(0, 8'h2C); ex(1, 8'h01); ex(1, 8'h21); ex(1, 8'h23); ex(1, 8'h04);
        cmp_events("R5");
        chk(rd == 8'h9E, "R5", "8-bit byte", rd, 8'h9E);
        chk(!oe_at23, "R5", "data released", oe_at23, 0);
        chk(pp_data_oe, "R5", "data driven after", pp_data_oe, 1);
    endtask

    task automatic t_writes();
        logic [7:0] rd; logic er;
        do_req(1'b0, 7'h03, 1'b1, 8'h5A, 3'd1, 1'b0, rd, er);
        ex(0, 8'h1A); ex(1, 8'h01); ex(0, 8'h5A); ex(1, 8'h03); ex(1, 8'h04);
        cmp_events("R6");
        do_req(1'b1, 7'h06, 1'b1, 8'h3C, 3'd2, 1'b0, rd, er);
        ex(0, 8'h9F); ex(1, 8'h01); ex(0, 8'h3C); ex(1, 8'h03); ex(1, 8'h04);
        cmp_events("R6");
    endtask

    task automatic t_epp();
        logic [7:0] rd; logic er;
        do_req(1'b1, 7'h11, 1'b1, 8'h77, 3'd4, 1'b0, rd, er);
        ex(2, 8'hD1); ex(3, 8'h77); ex(1, 8'h04);
        cmp_events("R7");
        do_req(1'b0, 7'h12, 1'b0, 8'h00, 3'd5, 1'b0, rd, er);
        ex(2, 8'h12); ex(1, 8'h24); ex(4, 0); ex(1, 8'h04);
        cmp_events("R8");
        chk(rd == 8'hC3, "R8", "epp read byte", rd, 8'hC3);
    endtask

    task automatic t_bad_mode();
        logic [7:0] rd; logic er;
        do_req(1'b1, 7'h22, 1'b1, 8'h11, 3'd6, 1'b0, rd, er);
        cmp_events("R11");
        chk(rd == 8'hFF, "R11", "bad mode byte", rd, 8'hFF);
        chk(er, "R11", "err", er, 1);
        do_req(1'b0, 7'h01, 1'b0, 8'h00, 3'd7, 1'b0, rd, er);
        cmp_events("R11");
        chk(er && rd == 8'hFF, "R11", "mode 7", {er, rd}, 9'h1FF);
    endtask

    task automatic t_gap();
        logic [7:0] rd; logic er;
        int mn;
        cfg_gap = 8'd3;
        do_req(1'b0, 7'h07, 1'b0, 8'h00, 3'd0, 1'b0, rd, er);
        ex(0, 8'h3E); ex(1, 8'h01); ex(1, 8'h03); ex(1, 8'h01); ex(1, 8'h04);
        cmp_events("R9");
        mn = 1000;
        for (int i = 1; i < ev_n && i < 64; i++)
            if (ev_c[i] - ev_c[i-1] < mn) mn = ev_c[i] - ev_c[i-1];
        chk(mn >= 4, "R9", "min spacing", mn, 4);
        chk(rd == 8'h3A, "R9", "byte under gap", rd, 8'h3A);
        cfg_gap = 8'd0;
    endtask

    task automatic t_busy_ignore();
        logic [7:0] rd; logic er;
        do_req(1'b0, 7'h01, 1'b1, 8'hEE, 3'd3, 1'b1, rd, er);
        repeat (20) @(negedge clk);
        ex(2, 8'h41); ex(3, 8'hEE);
        cmp_events("R10");
        chk(!busy && !done, "R10", "no second request", {busy, done}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_nib_read();
        t_nib_ctrl_bank();
        t_split_read();
        t_byte_read();
        t_writes();
        t_epp();
        t_bad_mode();
        t_gap();
        t_busy_ignore();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule